// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast oscillator clock by an integer ratio that may change on every output period. Its output is the feedback edge for a phase detector. Internally it models a dual-modulus prescaler, dividing by 8 or by 9, which is steered by two counters. A program counter P counts prescaler periods. A swallow counter S picks how many of those periods use the longer modulus. One divide cycle therefore lasts N = 8·P + S input clocks.

The ratio for each cycle is the sum of a 6-bit unsigned base word and a 4-bit signed offset from a noise-shaping modulator. The sum is captured only when the program counter reloads, so a ratio cannot change inside a cycle. A sum outside the legal window [N_MIN, N_MAX] (56 to 66 by default) would need S > P or a counter too wide for its register. Such a sum is clamped to the nearest bound, and a sticky error flag is raised. A synchronous reset loads the base word alone, clamped to the window, and ignores the offset.

Top module: `pswallow_div`

## Requirements
- R1: While `rst` is high, `div_out` and `range_err` are 0. The first `div_out` pulse comes N input clocks after the last reset edge, where N is the reset ratio.
- R2: With a constant legal ratio N in [56, 66], rising edges of `div_out` are exactly N input clocks apart, for every N in that window.
- R3: The internal counts never leave their range: 1 ≤ P ≤ N_MAX/8 and S ≤ P at all times.
- R4: `div_out` is high for exactly one input clock per divide cycle.
- R5: The effective ratio is `base` plus `ofs`, with `ofs` read as a 4-bit two's-complement value (-8 to +7). For example, 4'hA adds -6.
- R6: The ratio is sampled only at the input clock edge that raises `div_out`. Changes to `base` or `ofs` at any other time do not affect the cycle in progress.
- R7: A sum below 56 divides by 56 and sets `range_err`.
- R8: A sum above 66 divides by 66 and sets `range_err`.
- R9: Once set, `range_err` stays 1 until reset, even when later ratios are legal. Reset clears it.
- R10: Over a window of K·N input clocks at a constant ratio N, starting right after a pulse, exactly K pulses occur.
- R11: During reset the offset is ignored. The first cycle after reset uses `base` alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock from the oscillator |
| rst | input | 1 | Synchronous reset, active high |
| base | input | 6 | Unsigned base division ratio |
| ofs | input | 4 | Signed modulator offset added to the base |
| div_out | output | 1 | One-clock pulse per divide cycle, the phase detector feedback |
| range_err | output | 1 | Sticky flag: an out-of-window ratio was clamped |

## Verification
The assertions rely on the default window starting at 56. This keeps every divide cycle far longer than two clocks, and ensures S ≤ P holds for any clamped ratio. They also assume `rst` is driven synchronously.

The stimulus changes `base` and `ofs` only at falling edges, usually just after a pulse. The latch test deliberately changes them mid-cycle. Every value driven lies within the port widths. Some sums are chosen on purpose to fall outside the window, for the clamp requirements.

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int BASE_W  = 6,
  parameter int OFS_W   = 4,
  parameter int PRE_LOG = 3,
  parameter int N_MIN   = 56,
  parameter int N_MAX   = 66
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BASE_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  output logic              div_out,
  output logic              range_err
);
  localparam int PRE   = 1 << PRE_LOG;
  localparam int S_W   = PRE_LOG;
  localparam int P_W   = $clog2(N_MAX / PRE + 1);
  localparam int SUM_W = BASE_W + 2;
  localparam int C_W   = PRE_LOG + 1;

  logic [C_W-1:0]          pre_cnt;
  logic [P_W-1:0]          p_cnt;
  logic [S_W-1:0]          s_cnt;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] req;
  logic                    too_lo, too_hi, reload, pre_tc;
  logic [SUM_W-1:0]        n_load;
  logic [P_W-1:0]          p_new;
  logic [S_W-1:0]          s_new, s_dec;

  assign sum    = $signed({2'b00, base}) + $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
  assign req    = rst ? $signed({2'b00, base}) : sum;
  assign too_lo = req < $signed(SUM_W'(N_MIN));
  assign too_hi = req > $signed(SUM_W'(N_MAX));
  assign n_load = too_lo ? SUM_W'(N_MIN) : too_hi ? SUM_W'(N_MAX) : req;
  assign p_new  = P_W'(n_load >> S_W);
  assign s_new  = n_load[S_W-1:0];
  assign s_dec  = s_cnt - S_W'(s_cnt != '0);

  assign pre_tc = pre_cnt == '0;
  assign reload = rst || (pre_tc && p_cnt == P_W'(1));

  always_ff @(posedge clk) begin
    if (reload) begin
      p_cnt   <= p_new;
      s_cnt   <= s_new;
      pre_cnt <= (s_new != '0) ? C_W'(PRE) : C_W'(PRE - 1);
    end else if (pre_tc) begin
      p_cnt   <= p_cnt - P_W'(1);
      s_cnt   <= s_dec;
      pre_cnt <= (s_dec != '0) ? C_W'(PRE) : C_W'(PRE - 1);
    end else begin
      pre_cnt <= pre_cnt - C_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    div_out <= !rst && reload;
    if (rst)
      range_err <= 1'b0;
    else if (reload && (too_lo || too_hi))
      range_err <= 1'b1;
  end
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
  parameter int P_W   = 4,
  parameter int S_W   = 3,
  parameter int P_MAX = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           div_out,
  input logic           range_err,
  input logic           pre_tc,
  input logic [P_W-1:0] p_cnt,
  input logic [S_W-1:0] s_cnt
);
  AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (p_cnt >= P_W'(1)) && (p_cnt <= P_W'(P_MAX)) && (P_W'(s_cnt) <= p_cnt)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    range_err |=> range_err); // R9
  AST_P_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pre_tc |=> $stable(p_cnt)); // R6
  AST_PULSE_AT_TC: assert property (@(posedge clk) disable iff (rst)
    $rose(div_out) |-> $past(pre_tc)); // R2
endmodule

bind pswallow_div pswallow_div_chk #(.P_W(P_W), .S_W(S_W), .P_MAX(N_MAX / PRE)) u_chk (
  .clk(clk), .rst(rst), .div_out(div_out), .range_err(range_err),
  .pre_tc(pre_tc), .p_cnt(p_cnt), .s_cnt(s_cnt)
);

// File: tb/test_pswallow_div.sv
module test_pswallow_div;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] base = 6'd60;
  logic [3:0] ofs = 4'd0;
  logic       div_out, range_err;
  int         cyc = 0;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  pswallow_div i_pswallow_div (
    .clk(clk), .rst(rst), .base(base), .ofs(ofs),
    .div_out(div_out), .range_err(range_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (cyc > WATCHDOG && !done) begin
    done = 1;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [5:0] b, input logic [3:0] o, output int t0);
    @(negedge clk);
    rst = 1; base = b; ofs = o;
    @(negedge clk);
    @(negedge clk);
    chk(div_out == 0, "R1 div_out in reset", div_out, 0);
    chk(range_err == 0, "R1 range_err in reset", range_err, 0);
    t0 = cyc;
    rst = 0;
  endtask

  task automatic next_pulse(output int t);
    do @(negedge clk); while (!div_out);
    t = cyc;
  endtask

  // apply a ratio right after a pulse, return the period of the cycle that uses it
  task automatic apply_and_measure(input logic [5:0] b, input logic [3:0] o, output int per);
    int p0, p1, p2;
    next_pulse(p0);
    base = b; ofs = o;
    next_pulse(p1);
    next_pulse(p2);
    per = p2 - p1;
  endtask

  task automatic t_reset;
    int t0, t1;
    do_reset(6'd60, 4'hD, t0);
    next_pulse(t1);
    chk(t1 - t0 == 60, "R1 R11 first pulse uses base only", t1 - t0, 60);
    @(negedge clk);
    chk(div_out == 0, "R4 pulse lasts one clock", div_out, 0);
    chk(range_err == 0, "R11 no error at legal base", range_err, 0);
  endtask

  task automatic t_sweep;
    int t0, per;
    do_reset(6'd60, 4'd0, t0);
    for (int n = 56; n <= 66; n++) begin
      if (n <= 63) apply_and_measure(6'(n), 4'd0, per);
      else         apply_and_measure(6'd63, 4'(n - 63), per);
      chk(per == n, "R2 R5 period equals ratio", per, n);
    end
    chk(range_err == 0, "R2 no error in window", range_err, 0);
  endtask

  task automatic t_negative;
    int per;
    apply_and_measure(6'd62, 4'hA, per);
    chk(per == 56, "R5 negative offset -6", per, 56);
    apply_and_measure(6'd57, 4'h8, per);
    chk(per == 56 && range_err, "R5 R7 offset -8 gives 49, clamped", per, 56);
  endtask

  task automatic t_latch;
    int t0, p0, p1, p2;
    do_reset(6'd58, 4'd0, t0);
    next_pulse(p0);
    repeat (3) @(negedge clk);
    base = 6'd63; ofs = 4'd1;
    repeat (20) @(negedge clk);
    base = 6'd61; ofs = 4'd0;
    next_pulse(p1);
    next_pulse(p2);
    chk(p1 - p0 == 58, "R6 mid-cycle change ignored", p1 - p0, 58);
    chk(p2 - p1 == 61, "R6 value at reload edge used", p2 - p1, 61);
  endtask

  task automatic t_clamp;
    int t0, per;
    do_reset(6'd60, 4'd0, t0);
    apply_and_measure(6'd50, 4'h8, per);
    chk(per == 56, "R7 low clamp to 56", per, 56);
    chk(range_err == 1, "R7 error flag set", range_err, 1);
    do_reset(6'd60, 4'd0, t0);
    chk(range_err == 0, "R9 reset clears flag", range_err, 0);
    apply_and_measure(6'd63, 4'd7, per);
    chk(per == 66, "R8 high clamp to 66", per, 66);
    chk(range_err == 1, "R8 error flag set", range_err, 1);
    apply_and_measure(6'd60, 4'd0, per);
    chk(per == 60, "R9 legal ratio after clamp", per, 60);
    chk(range_err == 1, "R9 flag stays set", range_err, 1);
  endtask

  task automatic t_count;
    int t0, per, cnt;
    do_reset(6'd59, 4'd0, t0);
    apply_and_measure(6'd59, 4'd0, per);
    cnt = 0;
    for (int i = 0; i < 20 * 59; i++) begin
      @(negedge clk);
      if (div_out) cnt++;
    end
    chk(cnt == 20, "R10 K pulses in K*N clocks", cnt, 20);
  endtask

  initial begin
    t_reset;
    t_sweep;
    t_negative;
    t_latch;
    t_clamp;
    t_count;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule